// File: doc/BRIEF.md
# Jump Target Register Unit

This unit keeps one software-computed branch destination on hand for the instruction fetch front-end. A program works out where it will branch well before the branch. A typical case is reading the next entry of a dispatch table. The back-end writes that address here with a set-target operation, and a later jump-to-target instruction in the front-end redirects fetch to it with no prediction involved.

A validity flag protects the register. Any jump the processor takes marks the stored target stale, and this includes a jump-to-target that is accepted. A jump-to-target against a stale or never-written target raises a trap instead of redirecting. When a set-target has issued but not yet completed, a jump-to-target request is held. The front-end sees a stall, and the redirect goes out with the fresh address once every outstanding write has landed. For interrupt entry and exit, the address and the flag can be read out and written back in one cycle.

Top module: `jtr_unit`

## Requirements
- R1: After reset the invalid flag reads 1 on `save_inval_o`, and `redir_valid_o`, `trap_o` and `stall_o` are all 0.
- R2: A set-target completion (`set_done_i`) writes `set_addr_i` and clears the invalid flag. Both show on the save port in the next cycle.
- R3: A retiring jump (`jmp_retire_i`) sets the invalid flag to 1. When a completion and a retiring jump arrive in the same cycle, the flag ends at 1.
- R4: A jump-to-target request made while nothing is pending and the flag is 1 makes `trap_o` high for exactly one cycle, in the cycle after the request, with `redir_valid_o` low.
- R5: A request made while nothing is pending and the flag is 0 makes `redir_valid_o` high for exactly one cycle, in the cycle after the request, with `redir_addr_o` equal to the stored address. The accepted redirect sets the flag to 1, so a second request traps.
- R6: A request made while a set-target is outstanding is held. `stall_o` is high from the next cycle until the outstanding writes have landed. A single redirect to the newly written address then follows, and nothing is redirected while the write is still pending.
- R7: Issues and completions are counted. The pending state clears only when the number of completions equals the number of issues, so after two issues and one completion a request is still held.
- R8: `restore_i` loads the address and the flag from `restore_addr_i` and `restore_inval_i` in one cycle. It clears the pending state and any held request, and no redirect or trap results from the held request.
- R9: `redir_valid_o` and `trap_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_issue_i | input | 1 | Set-target operation issued in the back-end |
| set_done_i | input | 1 | Set-target operation completed, with `set_addr_i` valid |
| set_addr_i | input | ADDR_W | Target address written on completion |
| jmp_retire_i | input | 1 | Some other jump has retired |
| jtt_req_i | input | 1 | Front-end jump-to-target request (single-cycle pulse) |
| restore_i | input | 1 | Load saved target state |
| restore_addr_i | input | ADDR_W | Address to restore |
| restore_inval_i | input | 1 | Invalid flag to restore |
| save_addr_o | output | ADDR_W | Current stored address, for saving |
| save_inval_o | output | 1 | Current invalid flag, for saving |
| redir_valid_o | output | 1 | One-cycle redirect strobe |
| redir_addr_o | output | ADDR_W | Redirect address |
| stall_o | output | 1 | A request is held waiting for a target write |
| trap_o | output | 1 | One-cycle trap on a stale target |

## Verification
The bench aims at the collisions in the flag update and the pending logic. A completion that coincides with a retiring jump must leave the flag invalid; a design that lets the write win would later redirect to a stale address instead of trapping. With two writes outstanding and only one completed, a design that tracks a single pending bit would redirect early to the older address. A restore issued over a held request must drop that request without a spurious redirect, and a request arriving straight after an accepted redirect must trap, because the redirect counts as a jump.

// File: rtl/jtr_pkg.sv
package jtr_pkg;
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_WAIT = 2'd1,
    RES_TRAP = 2'd2,
    RES_GO   = 2'd3
  } jtr_res_e;
endpackage

// File: rtl/jtr_pend_track.sv
module jtr_pend_track #(
  parameter int SEQ_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  input  logic done_i,
  input  logic restore_i,
  output logic pending_o
);
  logic [SEQ_W-1:0] iss_q, iss_d, don_q, don_d;
  logic             iss_en, don_en;

  assign pending_o = (iss_q != don_q);

  always_comb begin
    iss_en = restore_i | issue_i;
    don_en = restore_i | (done_i & (pending_o | issue_i));
    iss_d  = restore_i ? '0 : iss_q + 1'b1;
    don_d  = restore_i ? '0 : don_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_q <= '0;
      don_q <= '0;
    end else begin
      if (iss_en) iss_q <= iss_d;
      if (don_en) don_q <= don_d;
    end
  end

  AST_RESTORE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> !pending_o); // R8
  AST_PEND_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_o && !issue_i) |=> !pending_o); // R7
endmodule

// File: rtl/jtr_target_reg.sv
module jtr_target_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              kill_i,
  input  logic              restore_i,
  input  logic [ADDR_W-1:0] rest_addr_i,
  input  logic              rest_inval_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              inval_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              inval_q, inval_d;
  logic              addr_en;

  always_comb begin
    addr_en = restore_i | wr_i;
    addr_d  = restore_i ? rest_addr_i : wr_addr_i;
    if (restore_i)   inval_d = rest_inval_i;
    else if (kill_i) inval_d = 1'b1;
    else if (wr_i)   inval_d = 1'b0;
    else             inval_d = inval_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      inval_q <= 1'b1;
    end else begin
      if (addr_en) addr_q <= addr_d;
      inval_q <= inval_d;
    end
  end

  assign addr_o  = addr_q;
  assign inval_o = inval_q;

  AST_RETIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_i && !restore_i) |=> inval_o); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !kill_i && !restore_i) |=> (!inval_o && addr_o == $past(wr_addr_i))); // R2
endmodule

// File: rtl/jtr_decide.sv
module jtr_decide
  import jtr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              pending_i,
  input  logic              inval_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              restore_i,
  output logic              take_o,
  output logic              redir_valid_o,
  output logic [ADDR_W-1:0] redir_addr_o,
  output logic              trap_o,
  output logic              stall_o
);
  jtr_res_e          res;
  logic              want;
  logic              wait_q, wait_d;
  logic              go_q, trap_q;
  logic [ADDR_W-1:0] raddr_q;

  always_comb begin
    want = req_i | wait_q;
    if (restore_i || !want) res = RES_NONE;
    else if (pending_i)     res = RES_WAIT;
    else if (inval_i)       res = RES_TRAP;
    else                    res = RES_GO;
    wait_d = (res == RES_WAIT);
    take_o = (res == RES_GO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= 1'b0;
      go_q    <= 1'b0;
      trap_q  <= 1'b0;
      raddr_q <= '0;
    end else begin
      wait_q <= wait_d;
      go_q   <= take_o;
      trap_q <= (res == RES_TRAP);
      if (take_o) raddr_q <= addr_i;
    end
  end

  assign redir_valid_o = go_q;
  assign redir_addr_o  = raddr_q;
  assign trap_o        = trap_q;
  assign stall_o       = wait_q;

  AST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_valid_o && trap_o)); // R9
  AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_o |=> !redir_valid_o); // R5
  AST_TRAP_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(inval_i)); // R4
  AST_NO_GO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_o |-> !$past(pending_i)); // R6
endmodule

// File: rtl/jtr_unit.sv
module jtr_unit #(
  parameter int ADDR_W = 32,
  parameter int SEQ_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_issue_i,
  input  logic              set_done_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              jmp_retire_i,
  input  logic              jtt_req_i,
  input  logic              restore_i,
  input  logic [ADDR_W-1:0] restore_addr_i,
  input  logic              restore_inval_i,
  output logic [ADDR_W-1:0] save_addr_o,
  output logic              save_inval_o,
  output logic              redir_valid_o,
  output logic [ADDR_W-1:0] redir_addr_o,
  output logic              stall_o,
  output logic              trap_o
);
  logic              pending, take, inval;
  logic [ADDR_W-1:0] taddr;

  jtr_pend_track #(.SEQ_W(SEQ_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_i   (set_issue_i),
    .done_i    (set_done_i),
    .restore_i (restore_i),
    .pending_o (pending)
  );

  jtr_target_reg #(.ADDR_W(ADDR_W)) u_treg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (set_done_i),
    .wr_addr_i    (set_addr_i),
    .kill_i       (jmp_retire_i | take),
    .restore_i    (restore_i),
    .rest_addr_i  (restore_addr_i),
    .rest_inval_i (restore_inval_i),
    .addr_o       (taddr),
    .inval_o      (inval)
  );

  jtr_decide #(.ADDR_W(ADDR_W)) u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (jtt_req_i),
    .pending_i     (pending),
    .inval_i       (inval),
    .addr_i        (taddr),
    .restore_i     (restore_i),
    .take_o        (take),
    .redir_valid_o (redir_valid_o),
    .redir_addr_o  (redir_addr_o),
    .trap_o        (trap_o),
    .stall_o       (stall_o)
  );

  assign save_addr_o  = taddr;
  assign save_inval_o = inval;
endmodule

// File: tb/jtr_unit_tb.sv
module jtr_unit_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          set_issue_i = 1'b0, set_done_i = 1'b0, jmp_retire_i = 1'b0;
  logic          jtt_req_i = 1'b0, restore_i = 1'b0, restore_inval_i = 1'b0;
  logic [AW-1:0] set_addr_i = '0, restore_addr_i = '0;
  logic [AW-1:0] save_addr_o, redir_addr_o;
  logic          save_inval_o, redir_valid_o, stall_o, trap_o;

  int checks = 0;
  int errors = 0;
  logic [AW:0] exp_q[$];   // bit AW = trap, else redirect with address

  always #10 clk = ~clk;

  jtr_unit #(.ADDR_W(AW), .SEQ_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .set_issue_i(set_issue_i), .set_done_i(set_done_i), .set_addr_i(set_addr_i),
    .jmp_retire_i(jmp_retire_i), .jtt_req_i(jtt_req_i),
    .restore_i(restore_i), .restore_addr_i(restore_addr_i), .restore_inval_i(restore_inval_i),
    .save_addr_o(save_addr_o), .save_inval_o(save_inval_o),
    .redir_valid_o(redir_valid_o), .redir_addr_o(redir_addr_o),
    .stall_o(stall_o), .trap_o(trap_o)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    set_issue_i = 0; set_done_i = 0; jmp_retire_i = 0; jtt_req_i = 0; restore_i = 0;
  endtask

  task automatic expect_item(input bit is_trap, input logic [AW-1:0] a);
    exp_q.push_back({is_trap, is_trap ? {AW{1'b0}} : a});
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (redir_valid_o && trap_o) begin
        checks++; errors++;
        $display("FAIL R9: actual redir=1 trap=1 expected one of them");
      end else if (redir_valid_o || trap_o) begin
        logic [AW:0] got;
        got = {trap_o, trap_o ? {AW{1'b0}} : redir_addr_o};
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R4/R5/R6/R8: actual unexpected %h expected none", got);
        end else begin
          logic [AW:0] e;
          e = exp_q.pop_front();
          if (got !== e) begin
            errors++;
            $display("FAIL R4/R5/R6: actual %h expected %h", got, e);
          end
        end
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 inval", save_inval_o, 1);
    check("R1 stall", stall_o, 0);
    check("R1 redir", redir_valid_o, 0);
    check("R1 trap", trap_o, 0);

    // R4 request on never-written target traps
    jtt_req_i = 1; expect_item(1, 0); cyc();
    cyc(); cyc();

    // R2 write target
    set_issue_i = 1; set_done_i = 1; set_addr_i = 32'h0000_1A00; cyc();
    check("R2 addr", save_addr_o, 32'h0000_1A00);
    check("R2 inval", save_inval_o, 0);
    // R5 redirect, then second request traps
    jtt_req_i = 1; expect_item(0, 32'h0000_1A00); cyc();
    check("R5 inval after redirect", save_inval_o, 1);
    jtt_req_i = 1; expect_item(1, 0); cyc();
    cyc(); cyc();

    // R3 collision: retire wins
    set_issue_i = 1; set_done_i = 1; set_addr_i = 32'h0000_2B00; jmp_retire_i = 1; cyc();
    check("R3 collision inval", save_inval_o, 1);
    set_issue_i = 1; set_done_i = 1; set_addr_i = 32'h0000_2C00; cyc();
    check("R2 rewrite inval", save_inval_o, 0);
    jmp_retire_i = 1; cyc();
    check("R3 retire inval", save_inval_o, 1);
    jtt_req_i = 1; expect_item(1, 0); cyc();
    cyc(); cyc();

    // R6 held request
    set_issue_i = 1; cyc();
    jtt_req_i = 1; cyc();
    check("R6 stall", stall_o, 1);
    cyc();
    check("R6 stall held", stall_o, 1);
    set_done_i = 1; set_addr_i = 32'h0000_3D00; expect_item(0, 32'h0000_3D00); cyc();
    cyc(); cyc(); cyc();
    check("R6 stall released", stall_o, 0);

    // R7 two outstanding writes
    set_issue_i = 1; cyc();
    set_issue_i = 1; cyc();
    jtt_req_i = 1; cyc();
    set_done_i = 1; set_addr_i = 32'h0000_4E00; cyc();
    cyc();
    check("R7 still held", stall_o, 1);
    set_done_i = 1; set_addr_i = 32'h0000_4F00; expect_item(0, 32'h0000_4F00); cyc();
    cyc(); cyc(); cyc();
    check("R7 released", stall_o, 0);

    // R8 restore drops a held request
    set_issue_i = 1; cyc();
    jtt_req_i = 1; cyc();
    check("R8 held before restore", stall_o, 1);
    restore_i = 1; restore_addr_i = 32'h0000_5500; restore_inval_i = 0; cyc();
    cyc();
    check("R8 stall cleared", stall_o, 0);
    check("R8 addr", save_addr_o, 32'h0000_5500);
    check("R8 inval", save_inval_o, 0);
    jtt_req_i = 1; expect_item(0, 32'h0000_5500); cyc();
    cyc(); cyc();
    restore_i = 1; restore_addr_i = 32'h0000_6600; restore_inval_i = 1; cyc();
    check("R8 inval restored", save_inval_o, 1);
    jtt_req_i = 1; expect_item(1, 0); cyc();
    repeat (4) cyc();

    check("R5 scoreboard empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule